// File: doc/BRIEF.md
# Horizontal Sync Lock Detector

This block watches a stream of horizontal sync strobes that an upstream slicer has already pulled out of the video signal. Each strobe comes with a flag that says whether the sync tip amplitude was acceptable. All inputs are in the system clock domain. For each strobe the block measures the number of clock cycles since the previous strobe and compares it against a tolerance window around the expected line period. It then decides whether that line was good.

Two levels of lock are reported. The first is a fast per-line indicator that follows the verdict on the latest line. The second is a filtered lock bit that rises only after a long run of uninterrupted good lines. That run is roughly one second of lines in normal mode, or roughly a quarter of that in fast-switch mode. When the filtered lock falls, a sticky loss flag latches and stays set until software pulses a clear input. An input that goes silent is caught by a timeout, so a dead input always reads as unlocked.

Top module: `hsync_lock_detect`

## Requirements
- R1: The window is computed in whole clock cycles as LO = LINE_CYCLES*95/100 and HI = LINE_CYCLES*105/100, using integer division. A judged strobe is good only if its interval since the previous strobe lies in [LO, HI], both ends included. With LINE_CYCLES=100, intervals of 95 and 105 are good and 94 is bad.
- R2: A judged strobe is good only if `amp_ok` is 1 in the same cycle as the strobe. A strobe with `amp_ok`=0 is bad whatever its interval.
- R3: `lock` rises on the verdict of the N-th consecutive good strobe. N is FAST_LOCK_LINES when `fast_mode`=1 at that verdict, and STD_LOCK_LINES when `fast_mode`=0. Before that verdict, `lock` stays 0.
- R4: `inst_lock` is 1 exactly when the most recent verdict was good. Both `inst_lock` and `lock` update two clock cycles after the cycle in which the strobe is sampled.
- R5: A bad verdict sets the consecutive-good count to zero. It also drops `inst_lock` and `lock` in the same cycle.
- R6: If no strobe arrives within HI cycles of the last one, a bad verdict is issued and the block disarms.
- R7: The first strobe after reset or after a timeout only starts interval timing. It leaves all outputs unchanged.
- R8: `lost_lock` goes to 1 one cycle after `lock` falls and holds until `lost_clr` is pulsed. If a set and a clear fall on the same cycle, the set takes priority.
- R9: While `rst` is high and right after it, `inst_lock`, `lock` and `lost_lock` are 0.
- R10: The good count saturates at the threshold, so `lock` stays 1 through any run of good lines, however long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_pulse | input | 1 | One-cycle strobe per detected horizontal sync |
| amp_ok | input | 1 | Sync amplitude acceptable, sampled with `hs_pulse` |
| fast_mode | input | 1 | 1 selects the short settling threshold |
| lost_clr | input | 1 | One-cycle clear of `lost_lock` |
| inst_lock | output | 1 | Verdict of the latest judged line |
| lock | output | 1 | Filtered lock after a run of good lines |
| lost_lock | output | 1 | Sticky flag, set when `lock` falls |

## Verification
The bench builds the block with LINE_CYCLES=100, STD_LOCK_LINES=20 and FAST_LOCK_LINES=5. With these values LO and HI are exactly 95 and 105, so both window edges and the first interval outside them can be driven directly. The short thresholds let both the normal and fast-switch settling runs finish many times within a short run, including long saturated stretches. A 106-cycle silence is enough to exercise the timeout and re-arm path.

// File: rtl/hsync_lock_pkg.sv
package hsync_lock_pkg;

  typedef struct packed {
    logic valid;
    logic good;
  } line_verdict_t;

  function automatic int win_lo(input int period);
    return (period * 95) / 100;
  endfunction

  function automatic int win_hi(input int period);
    return (period * 105) / 100;
  endfunction

endpackage

// File: rtl/hs_line_timer.sv
module hs_line_timer
  import hsync_lock_pkg::*;
#(
  parameter int LINE_CYCLES = 6356
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_pulse,
  input  logic          amp_ok,
  output line_verdict_t verdict
);

  localparam int LO = win_lo(LINE_CYCLES);
  localparam int HI = win_hi(LINE_CYCLES);
  localparam int TW = $clog2(HI + 1);

  logic [TW-1:0] timer_q;
  logic          armed_q;
  line_verdict_t verdict_q;
  logic          in_window;

  assign in_window = (timer_q >= TW'(LO)) && (timer_q <= TW'(HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q   <= '0;
      armed_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      verdict_q <= '0;
      if (hs_pulse) begin
        timer_q <= TW'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          verdict_q.valid <= 1'b1;
          verdict_q.good  <= amp_ok && in_window;
        end
      end else if (armed_q) begin
        if (timer_q == TW'(HI)) begin
          armed_q         <= 1'b0;
          timer_q         <= '0;
          verdict_q.valid <= 1'b1;
          verdict_q.good  <= 1'b0;
        end else begin
          timer_q <= timer_q + TW'(1);
        end
      end
    end
  end

  assign verdict = verdict_q;

endmodule

// File: rtl/hs_lock_filter.sv
module hs_lock_filter
  import hsync_lock_pkg::*;
#(
  parameter int STD_LOCK_LINES  = 15734,
  parameter int FAST_LOCK_LINES = 3934
) (
  input  logic          clk,
  input  logic          rst,
  input  line_verdict_t verdict,
  input  logic          fast_mode,
  output logic          inst_lock,
  output logic          lock
);

  localparam int CW = $clog2(STD_LOCK_LINES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_nxt;
  logic          inst_q;
  logic          lock_q;

  assign thr     = fast_mode ? CW'(FAST_LOCK_LINES) : CW'(STD_LOCK_LINES);
  assign cnt_nxt = (cnt_q >= thr) ? thr : cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      inst_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (verdict.valid) begin
      if (verdict.good) begin
        cnt_q  <= cnt_nxt;
        inst_q <= 1'b1;
        lock_q <= (cnt_nxt >= thr);
      end else begin
        cnt_q  <= '0;
        inst_q <= 1'b0;
        lock_q <= 1'b0;
      end
    end
  end

  assign inst_lock = inst_q;
  assign lock      = lock_q;

endmodule

// File: rtl/hs_lost_sticky.sv
module hs_lost_sticky (
  input  logic clk,
  input  logic rst,
  input  logic lock,
  input  logic clr,
  output logic lost
);

  logic lock_d;
  logic lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_d <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      lock_d <= lock;
      if (lock_d && !lock) begin
        lost_q <= 1'b1;
      end else if (clr) begin
        lost_q <= 1'b0;
      end
    end
  end

  assign lost = lost_q;

endmodule

// File: rtl/hsync_lock_detect.sv
module hsync_lock_detect
  import hsync_lock_pkg::*;
#(
  parameter int LINE_CYCLES     = 6356,
  parameter int STD_LOCK_LINES  = 15734,
  parameter int FAST_LOCK_LINES = 3934
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_pulse,
  input  logic amp_ok,
  input  logic fast_mode,
  input  logic lost_clr,
  output logic inst_lock,
  output logic lock,
  output logic lost_lock
);

  line_verdict_t verdict;

  hs_line_timer #(.LINE_CYCLES(LINE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hs_pulse (hs_pulse),
    .amp_ok   (amp_ok),
    .verdict  (verdict)
  );

  hs_lock_filter #(
    .STD_LOCK_LINES  (STD_LOCK_LINES),
    .FAST_LOCK_LINES (FAST_LOCK_LINES)
  ) u_filter (
    .clk       (clk),
    .rst       (rst),
    .verdict   (verdict),
    .fast_mode (fast_mode),
    .inst_lock (inst_lock),
    .lock      (lock)
  );

  hs_lost_sticky u_lost (
    .clk  (clk),
    .rst  (rst),
    .lock (lock),
    .clr  (lost_clr),
    .lost (lost_lock)
  );

endmodule

// File: rtl/hsync_lock_chk.sv
module hsync_lock_chk (
  input logic clk,
  input logic rst,
  input logic hs_pulse,
  input logic lost_clr,
  input logic inst_lock,
  input logic lock,
  input logic lost_lock
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R9
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_state_chk: assert (!inst_lock && !lock && !lost_lock)
        else $error("outputs not clear after reset");
    end
  end

  // R4
  lock_needs_inst_chk: assert property (@(posedge clk) disable iff (rst)
    lock |-> inst_lock);

  // R3
  lock_rise_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(hs_pulse, 2));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lost_lock && !lost_clr) |=> lost_lock);

  // R8
  lost_rise_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_lock) |-> (!$past(lock) && $past(lock, 2)));

endmodule

bind hsync_lock_detect hsync_lock_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hs_pulse  (hs_pulse),
  .lost_clr  (lost_clr),
  .inst_lock (inst_lock),
  .lock      (lock),
  .lost_lock (lost_lock)
);

// File: tb/hsync_lock_detect_bench.sv
module hsync_lock_detect_bench;

  localparam int PER  = 100;
  localparam int STDN = 20;
  localparam int FSTN = 5;
  localparam int LO   = (PER * 95) / 100;
  localparam int HI   = (PER * 105) / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_pulse = 1'b0, amp_ok = 1'b0, fast_mode = 1'b0, lost_clr = 1'b0;
  logic inst_lock, lock, lost_lock;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit m_armed = 0, m_inst = 0, m_lock = 0, m_lost = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  hsync_lock_detect #(
    .LINE_CYCLES(PER), .STD_LOCK_LINES(STDN), .FAST_LOCK_LINES(FSTN)
  ) u_hsync_lock_detect (
    .clk(clk), .rst(rst), .hs_pulse(hs_pulse), .amp_ok(amp_ok),
    .fast_mode(fast_mode), .lost_clr(lost_clr),
    .inst_lock(inst_lock), .lock(lock), .lost_lock(lost_lock)
  );

  function automatic bit judge(int gap, bit amp);
    return amp && (gap >= LO) && (gap <= HI);
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    check(inst_lock, m_inst, req, "inst_lock");
    check(lock, m_lock, req, "lock");
    check(lost_lock, m_lost, req, "lost_lock");
  endtask

  task automatic apply_verdict(bit g, bit clr);
    bit prev;
    bit set;
    int thr;
    prev = m_lock;
    thr  = fast_mode ? FSTN : STDN;
    if (g) begin
      m_cnt  = (m_cnt >= thr) ? thr : m_cnt + 1;
      m_inst = 1;
      m_lock = (m_cnt >= thr);
    end else begin
      m_cnt = 0; m_inst = 0; m_lock = 0;
    end
    set = prev && !m_lock;
    if (set) m_lost = 1;
    else if (clr) m_lost = 0;
  endtask

  // strobe 'gap' cycles after the previous one; outputs checked 3 cycles after
  task automatic pulse(int gap, bit amp, bit clr, string req);
    repeat (gap - 3) @(negedge clk);
    hs_pulse = 1; amp_ok = amp;
    @(negedge clk);
    hs_pulse = 0; amp_ok = 0;
    @(negedge clk);
    lost_clr = clr;
    @(negedge clk);
    lost_clr = 0;
    if (!m_armed) begin
      m_armed = 1;
      if (clr) m_lost = 0;
    end else begin
      apply_verdict(judge(gap, amp), clr);
    end
    check_all(req);
  endtask

  task automatic silence(string req);
    repeat (120) @(negedge clk);
    if (m_armed) begin
      apply_verdict(0, 0);
      m_armed = 0;
    end
    check_all(req);
  endtask

  task automatic clear_lost();
    @(negedge clk); lost_clr = 1;
    @(negedge clk); lost_clr = 0;
    m_lost = 0;
    check(lost_lock, 0, "R8", "lost_lock after clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    check_all("R9");
    rst = 0;
    @(negedge clk);
    check_all("R9");

    // R7: arming strobe changes nothing
    pulse(100, 1, 0, "R7");
    for (int i = 1; i <= STDN; i++) begin
      pulse(100, 1, 0, (i == STDN) ? "R3" : "R4");
    end
    // R1: window edges
    pulse(95, 1, 0, "R1");
    pulse(105, 1, 0, "R1");
    for (int i = 0; i < 30; i++) pulse(100, 1, 0, "R10");
    pulse(94, 1, 0, "R5");
    clear_lost();
    pulse(100, 0, 0, "R2");
    pulse(100, 1, 0, "R4");
    silence("R6");
    pulse(100, 1, 0, "R7");

    fast_mode = 1;
    for (int i = 1; i <= FSTN; i++) pulse(101, 1, 0, "R3");
    // R8: set and clear on the same cycle, set wins
    pulse(100, 0, 1, "R8");
    pulse(100, 1, 1, "R8");
    check(lost_lock, 0, "R8", "cleared by clr without set");

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      r = int'($urandom % 100);
      if (r < 82)      pulse(LO + int'($urandom % (HI - LO + 1)), 1, ($urandom % 16) == 0, "R4");
      else if (r < 89) pulse(60 + int'($urandom % (LO - 60)), 1, 0, "R1");
      else if (r < 95) pulse(LO + int'($urandom % (HI - LO + 1)), 0, 0, "R2");
      else begin
        silence("R6");
        fast_mode = $urandom % 2;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule